// File: doc/BRIEF.md
# Dual-Port Receiver Input Scanner

This block brings up a two-input video receiver front end and then hunts for an attached source. First it holds the receiver in reset through an active-low reset output. It then waits a settle time with both hot-plug-detect outputs released (high). After that it pulls both hot-plug-detect outputs low, which enables both inputs, and it selects port 1 as the active input.

While scanning, the block polls an active-low interrupt line together with a source-detect status bit. If no source shows up within a fixed dwell of three seconds, it switches the active input to the other port. This repeats, alternating between the two ports. When a source is seen, the block stops hunting and runs three handshakes in a fixed order:
- an authentication request,
- a format-readout request,
- a single-cycle colour-configuration request.

Once the configuration is acknowledged, it raises a locked status. A source loss that outlasts a debounce window, at any point after detection, sends the block back to scanning on the other port.

The dwell is counted in clock cycles from a clock-frequency parameter, so a short test configuration is possible.

Top module: `rx_port_scanner`

## Requirements
- R1: `rx_rst_n` is low while `rst_n` is low and for exactly RST_CYCLES clock cycles after `rst_n` is released, then stays high.
- R2: `hpd_n` is 2'b11 (both ports disabled) while the receiver is in reset and for SETTLE_CYCLES cycles after `rx_rst_n` rises; it then becomes 2'b00 and stays low.
- R3: When `hpd_n` first goes low, `act_port` is 0, which selects port 1 (a value of 1 selects port 2).
- R4: While scanning with no detection, `act_port` toggles once every DWELL_SEC*CLK_HZ cycles.
- R5: A detection occurs only at a clock edge where `irq_n` is low and `src_det` is high during scanning. `src_det` high with `irq_n` high has no effect. On detection, `auth_req` rises and stays high until `auth_done` is sampled high.
- R6: After `auth_done`, `fmt_req` is high from the next cycle until `fmt_done` is sampled high.
- R7: After `fmt_done`, `cfg_req` is high for exactly one cycle. `locked` then rises in the cycle after `cfg_done` is first sampled high. At most one of `auth_req`, `fmt_req`, `cfg_req` and `locked` is high at a time.
- R8: `act_port` never changes outside scanning; it holds its value during detection, handshakes and lock, however long they last.
- R9: After detection, `src_det` low for LOSS_CYCLES consecutive edges drops all requests and `locked`. One cycle later, `act_port` switches to the other port and scanning resumes. Gaps of `src_det` shorter than LOSS_CYCLES have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rx_rst_n | output | 1 | Active-low receiver reset |
| hpd_n | output | 2 | Active-low hot-plug-detect enables; bit 0 is port 1, bit 1 is port 2 |
| act_port | output | 1 | Active input select: 0 is port 1, 1 is port 2 |
| irq_n | input | 1 | Active-low receiver interrupt |
| src_det | input | 1 | Source present on the active port |
| auth_req | output | 1 | Authentication request, level |
| auth_done | input | 1 | Authentication finished |
| fmt_req | output | 1 | Input format readout request, level |
| fmt_done | input | 1 | Format readout finished |
| cfg_req | output | 1 | Colour configuration request, single cycle |
| cfg_done | input | 1 | Configuration finished |
| locked | output | 1 | Source locked and configured |

## Verification
The assertions assume the following about the inputs:
- Each done input is only raised while its own request is pending.
- Inputs change away from the rising clock edge.

The stimulus drives every input on the falling edge. It pulses each done line for one cycle, and only after the matching request has been observed high.

Source-loss stimulus covers two cases: gaps one cycle shorter than the debounce window, and gaps exactly as long as the window.

// File: rtl/rx_port_scanner.sv
module rx_port_scanner #(
  parameter int CLK_HZ        = 27_000_000,
  parameter int DWELL_SEC     = 3,
  parameter int RST_CYCLES    = 64,
  parameter int SETTLE_CYCLES = 256,
  parameter int LOSS_CYCLES   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       rx_rst_n,
  output logic [1:0] hpd_n,
  output logic       act_port,
  input  logic       irq_n,
  input  logic       src_det,
  output logic       auth_req,
  input  logic       auth_done,
  output logic       fmt_req,
  input  logic       fmt_done,
  output logic       cfg_req,
  input  logic       cfg_done,
  output logic       locked
);

  localparam int DWELL = CLK_HZ * DWELL_SEC;
  localparam int M1    = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
  localparam int MAXC  = (DWELL > M1) ? DWELL : M1;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int LW    = $clog2(LOSS_CYCLES + 1);

  typedef enum logic [2:0] {
    S_RESET, S_SETTLE, S_SCAN, S_AUTH, S_FMT, S_CFG, S_WAIT, S_LOCK
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [LW-1:0] lcnt;

  wire tracking  = (state == S_AUTH) || (state == S_FMT) || (state == S_CFG) ||
                   (state == S_WAIT) || (state == S_LOCK);
  wire lost      = tracking && !src_det && (lcnt == LW'(LOSS_CYCLES - 1));
  wire detect    = !irq_n && src_det;
  wire dwell_end = (cnt == CW'(DWELL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_RESET;
      cnt      <= '0;
      lcnt     <= '0;
      act_port <= 1'b0;
    end else begin
      if (!tracking || src_det) lcnt <= '0;
      else                      lcnt <= lcnt + 1'b1;

      if (lost) begin
        state <= S_SCAN;
        cnt   <= CW'(DWELL - 1);
        lcnt  <= '0;
      end else begin
        case (state)
          S_RESET: begin
            if (cnt == CW'(RST_CYCLES - 1)) begin
              state <= S_SETTLE;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_SETTLE: begin
            if (cnt == CW'(SETTLE_CYCLES - 1)) begin
              state    <= S_SCAN;
              cnt      <= '0;
              act_port <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
          S_SCAN: begin
            if (detect) begin
              state <= S_AUTH;
              cnt   <= '0;
            end else if (dwell_end) begin
              act_port <= ~act_port;
              cnt      <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_AUTH:  if (auth_done) state <= S_FMT;
          S_FMT:   if (fmt_done)  state <= S_CFG;
          S_CFG:   state <= S_WAIT;
          S_WAIT:  if (cfg_done)  state <= S_LOCK;
          default: ;
        endcase
      end
    end
  end

  assign rx_rst_n = (state != S_RESET);
  assign hpd_n    = (state == S_RESET || state == S_SETTLE) ? 2'b11 : 2'b00;
  assign auth_req = (state == S_AUTH);
  assign fmt_req  = (state == S_FMT);
  assign cfg_req  = (state == S_CFG);
  assign locked   = (state == S_LOCK);

  a_r2_hpd_off_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rst_n |-> hpd_n == 2'b11);

  a_r1_reset_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_rst_n) |-> rx_rst_n);

  a_r8_port_moves_only_scanning: assert property (@(posedge clk) disable iff (!rst_n)
    (act_port != $past(act_port)) |-> ($past(state) == S_SCAN && $past(dwell_end)));

  a_r5_entry_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auth_req) |-> $past(!irq_n && src_det));

  a_r7_cfg_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> !cfg_req);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({auth_req, fmt_req, cfg_req, locked}));

  a_r7_lock_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cfg_done));

  a_r9_unlock_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(!src_det));

endmodule

// File: tb/rx_port_scanner_tb_top.sv
module rx_port_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 10, SEC = 3, RSTC = 4, SETC = 5, LOSS = 3;
  localparam int DW = HZ * SEC;

  logic clk = 0, rst_n = 0;
  logic irq_n = 1, src_det = 0, auth_done = 0, fmt_done = 0, cfg_done = 0;
  logic rx_rst_n, act_port, auth_req, fmt_req, cfg_req, locked;
  logic [1:0] hpd_n;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_port_scanner #(.CLK_HZ(HZ), .DWELL_SEC(SEC), .RST_CYCLES(RSTC),
                    .SETTLE_CYCLES(SETC), .LOSS_CYCLES(LOSS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_rst_n(rx_rst_n), .hpd_n(hpd_n),
    .act_port(act_port), .irq_n(irq_n), .src_det(src_det),
    .auth_req(auth_req), .auth_done(auth_done), .fmt_req(fmt_req),
    .fmt_done(fmt_done), .cfg_req(cfg_req), .cfg_done(cfg_done), .locked(locked));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rx_rst_n", rx_rst_n, 0);
    chk("R2 reset hpd_n", hpd_n, 3);
    chk("R7 reset locked/req", {locked, auth_req, fmt_req, cfg_req}, 0);
    rst_n = 1;
    tick(RSTC - 1);
    chk("R1 rx_rst_n held", rx_rst_n, 0);
    tick(1);
    chk("R1 rx_rst_n released", rx_rst_n, 1);
    chk("R2 hpd during settle", hpd_n, 3);
    tick(SETC - 1);
    chk("R2 hpd end of settle", hpd_n, 3);
    tick(1);
    chk("R2 hpd enabled", hpd_n, 0);
    chk("R3 first port", act_port, 0);
    for (int i = 0; i < 4; i++) begin
      tick(DW - 1);
      chk("R4 before dwell end", act_port, i & 1);
      tick(1);
      chk("R4 after dwell end", act_port, (i & 1) ^ 1);
    end
    src_det = 1;
    tick(10);
    chk("R5 src without irq ignored", auth_req, 0);
    chk("R5 no port change", act_port, 0);
    irq_n = 0;
    tick(1);
    irq_n = 1;
    chk("R5 auth_req on detect", auth_req, 1);
    tick(3);
    chk("R5 auth_req held", {auth_req, fmt_req}, 2);
    auth_done = 1; tick(1); auth_done = 0;
    chk("R6 fmt_req after auth", {auth_req, fmt_req}, 1);
    tick(2);
    chk("R6 fmt_req held", fmt_req, 1);
    fmt_done = 1; tick(1); fmt_done = 0;
    chk("R7 cfg_req pulse", {fmt_req, cfg_req}, 1);
    tick(1);
    chk("R7 cfg_req one cycle", {cfg_req, locked}, 0);
    tick(2);
    chk("R7 waiting for done", locked, 0);
    cfg_done = 1; tick(1); cfg_done = 0;
    chk("R7 locked", locked, 1);
    tick(2 * DW);
    chk("R8 port held while locked", act_port, 0);
    chk("R8 still locked", locked, 1);
    src_det = 0; tick(LOSS - 1); src_det = 1; tick(1);
    chk("R9 short gap ignored", locked, 1);
    src_det = 0;
    tick(LOSS - 1);
    chk("R9 locked before window", locked, 1);
    tick(1);
    chk("R9 unlocked on loss", locked, 0);
    chk("R8 port unchanged at unlock", act_port, 0);
    tick(1);
    chk("R9 switched port", act_port, 1);
    tick(5);
    src_det = 1; irq_n = 0; tick(1); irq_n = 1;
    chk("R5 detect on port 2", {auth_req, act_port}, 3);
    src_det = 0;
    tick(LOSS);
    chk("R9 loss during auth", {auth_req, locked}, 0);
    tick(1);
    chk("R9 switched back", act_port, 0);
    tick(DW - 1);
    chk("R4 dwell resumes", act_port, 0);
    tick(1);
    chk("R4 dwell toggle", act_port, 1);
    finished = 1;
    summary();
  end
endmodule